// File: doc/BRIEF.md
# Nonvolatile Copy Sequencer with Write Confirmation

This block copies a fixed window of on-chip RAM into an external nonvolatile byte memory, one byte per write command. It supports two jobs. The configuration job moves a 20-byte image. The preset job moves a 7-byte record that holds a preset position followed by its checksum. Each job has its own fixed source base and destination base, so the destination address is always the source address plus a per-job offset.

After every write the sequencer must know that the memory has finished storing the byte before it moves on. It can do this in one of two ways:
- **Timed mode:** it waits a parameterised number of clock cycles that stands for the memory's worst-case programming time.
- **Verify mode:** it reads the same address back until the value matches the byte it wrote. A mismatch means the memory is still busy. If the number of read-backs reaches a parameterised limit, the job stops with an error.

The RAM is reached through a byte read port with one cycle of latency. The nonvolatile memory is reached through a request/acknowledge command port that a separate serial-bus master serves. A start pulse in idle samples the job and mode selects.

Top module: `nvm_copy_seq`

## Requirements
- R1: The configuration job (`job_i`=0) copies RAM bytes 0x00..0x13 to nonvolatile addresses 0x10..0x23. Byte k goes to address 0x10+k, and bytes go in ascending order.
- R2: The preset job (`job_i`=1) copies the seven RAM bytes from 0x20 upward to nonvolatile addresses 0x48..0x4E, keeping their order.
- R3: Each write command carries one byte, and the job issues exactly as many write commands as the job has bytes. A new write is issued only after the previous byte has been confirmed.
- R4: In timed mode (`mode_i`=0), the next write request comes no sooner than WAIT_CYC cycles after the cycle in which a write was acknowledged. Timed mode issues no read commands.
- R5: In verify mode (`mode_i`=1), each write is followed by read commands (`nvm_we_o`=0) to the same address. The block does not advance until a read returns the written byte.
- R6: If MAX_TRIES read-backs in a row all mismatch, `error_o` rises and the job stops. No further write is issued, `done_o` does not pulse, and `busy_o` drops. `error_o` stays high until the next accepted start.
- R7: Job and mode are sampled only when a start is accepted. Changes on `job_i` and `mode_i` during a job have no effect.
- R8: A start pulse while `busy_o` is high is ignored.
- R9: `done_o` is a one-cycle pulse in the cycle after the last byte is confirmed. `busy_o` is high from the cycle after an accepted start until that cycle, and it is low whenever the block is idle.
- R10: After reset, `busy_o`, `done_o`, `error_o` and `nvm_req_o` are all low.
- R11: While `nvm_req_o` is high and `nvm_ack_i` is low, the request and its address, write flag and data all hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse; accepted only while idle |
| job_i | input | 1 | Job select: 0 = configuration, 1 = preset |
| mode_i | input | 1 | Completion select: 0 = timed wait, 1 = read-back verify |
| ram_addr_o | output | 8 | RAM read address |
| ram_rdata_i | input | 8 | RAM read data, valid one cycle after the address |
| nvm_req_o | output | 1 | Command request to the nonvolatile port |
| nvm_we_o | output | 1 | 1 = write command, 0 = read command |
| nvm_addr_o | output | 8 | Nonvolatile byte address |
| nvm_wdata_o | output | 8 | Byte to write (also the compare value while verifying) |
| nvm_ack_i | input | 1 | One-cycle command acknowledge |
| nvm_rdata_i | input | 8 | Read data, valid with `nvm_ack_i` |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Verify attempts exhausted |

## Verification
The bench drives inputs and samples outputs on the falling edge. Its memory model acknowledges a command two falling edges after it first sees the request, so the acknowledge lands at the following rising edge.

In timed mode the next write request appears WAIT_CYC+4 cycles after the acknowledged write. The four extra cycles are the advance, RAM address, RAM capture and write states. The bench checks this gap against the WAIT_CYC lower bound.

`done_o` and `error_o` appear one cycle after the deciding acknowledge or the last confirmation. The bench therefore waits on those outputs, and only then compares its operation counts, the destination image and the gap minimum against values it derives from the job table.

// File: rtl/nvm_copy_pkg.sv
package nvm_copy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RADDR,
    ST_RCAP,
    ST_WRITE,
    ST_WAIT,
    ST_VREAD,
    ST_ADV
  } seq_state_e;

  typedef enum logic {
    JOB_CFG    = 1'b0,
    JOB_PRESET = 1'b1
  } job_e;

  typedef enum logic {
    MODE_TIMED  = 1'b0,
    MODE_VERIFY = 1'b1
  } mode_e;

endpackage

// File: rtl/nvm_copy_window.sv
// Maps the job and byte index to source and destination addresses.
module nvm_copy_window import nvm_copy_pkg::*; #(
  parameter int AW      = 8,
  parameter int IW      = 5,
  parameter int CFG_SRC = 'h00,
  parameter int CFG_DST = 'h10,
  parameter int CFG_LEN = 20,
  parameter int PRE_SRC = 'h20,
  parameter int PRE_DST = 'h48,
  parameter int PRE_LEN = 7
) (
  input  job_e          job_i,
  input  logic [IW-1:0] idx_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          last_o
);

  localparam logic [AW-1:0] CFG_SRC_A = CFG_SRC[AW-1:0];
  localparam logic [AW-1:0] CFG_DST_A = CFG_DST[AW-1:0];
  localparam logic [AW-1:0] PRE_SRC_A = PRE_SRC[AW-1:0];
  localparam logic [AW-1:0] PRE_DST_A = PRE_DST[AW-1:0];
  localparam logic [IW-1:0] CFG_END   = IW'(CFG_LEN - 1);
  localparam logic [IW-1:0] PRE_END   = IW'(PRE_LEN - 1);

  logic [AW-1:0] idx_ext;

  assign idx_ext = AW'(idx_i);

  always_comb begin
    if (job_i == JOB_PRESET) begin
      src_o  = PRE_SRC_A + idx_ext;
      dst_o  = PRE_DST_A + idx_ext;
      last_o = (idx_i == PRE_END);
    end else begin
      src_o  = CFG_SRC_A + idx_ext;
      dst_o  = CFG_DST_A + idx_ext;
      last_o = (idx_i == CFG_END);
    end
  end

endmodule

// File: rtl/nvm_copy_wait.sv
// Down-counter for the post-write programming wait.
module nvm_copy_wait #(
  parameter int CYC = 800000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);

  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load_i | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = CW'(CYC - 1);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  // R4: a load always starts a fresh window below the limit
  a_r4_wait_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == CW'(CYC - 1)));

endmodule

// File: rtl/nvm_copy_tries.sv
// Counts mismatching read-backs of the current byte.
module nvm_copy_tries #(
  parameter int MAX_TRIES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_try_o
);

  localparam int TW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_try_o = (cnt_q == TW'(MAX_TRIES - 1));

  // R6: the count never passes the attempt limit
  a_r6_tries_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt_q) < MAX_TRIES));

endmodule

// File: rtl/nvm_copy_seq.sv
module nvm_copy_seq import nvm_copy_pkg::*; #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int CFG_SRC   = 'h00,
  parameter int CFG_DST   = 'h10,
  parameter int CFG_LEN   = 20,
  parameter int PRE_SRC   = 'h20,
  parameter int PRE_DST   = 'h48,
  parameter int PRE_LEN   = 7,
  parameter int WAIT_CYC  = 800000,
  parameter int MAX_TRIES = 8
) (
  input  logic          clk,
  input  logic          rst_n_i,
  input  logic          start_i,
  input  logic          job_i,
  input  logic          mode_i,
  output logic [AW-1:0] ram_addr_o,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          nvm_req_o,
  output logic          nvm_we_o,
  output logic [AW-1:0] nvm_addr_o,
  output logic [DW-1:0] nvm_wdata_o,
  input  logic          nvm_ack_i,
  input  logic [DW-1:0] nvm_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          error_o
);

  localparam int MAXLEN = (CFG_LEN > PRE_LEN) ? CFG_LEN : PRE_LEN;
  localparam int IW     = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_n = rst_sync_q[1];

  // Sequencer state
  seq_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  job_e          job_q, job_d;
  mode_e         mode_q, mode_d;
  logic [DW-1:0] wbyte_q, wbyte_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic [AW-1:0] wr_addr_q;

  logic [AW-1:0] src_addr, dst_addr;
  logic          last_byte;
  logic          wait_load, wait_expired;
  logic          tries_clr, tries_inc, last_try;
  logic          start_ok;

  nvm_copy_window #(
    .AW(AW), .IW(IW),
    .CFG_SRC(CFG_SRC), .CFG_DST(CFG_DST), .CFG_LEN(CFG_LEN),
    .PRE_SRC(PRE_SRC), .PRE_DST(PRE_DST), .PRE_LEN(PRE_LEN)
  ) u_window (
    .job_i  (job_q),
    .idx_i  (idx_q),
    .src_o  (src_addr),
    .dst_o  (dst_addr),
    .last_o (last_byte)
  );

  nvm_copy_wait #(.CYC(WAIT_CYC)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (wait_load),
    .expired_o (wait_expired)
  );

  nvm_copy_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (tries_clr),
    .inc_i      (tries_inc),
    .last_try_o (last_try)
  );

  assign start_ok = start_i & (state_q == ST_IDLE);

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    job_d     = job_q;
    mode_d    = mode_q;
    wbyte_d   = wbyte_q;
    err_d     = err_q;
    done_d    = 1'b0;
    wait_load = 1'b0;
    tries_clr = 1'b0;
    tries_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          job_d   = job_e'(job_i);
          mode_d  = mode_e'(mode_i);
          idx_d   = '0;
          err_d   = 1'b0;
          state_d = ST_RADDR;
        end
      end
      ST_RADDR: state_d = ST_RCAP;
      ST_RCAP: begin
        wbyte_d = ram_rdata_i;
        state_d = ST_WRITE;
      end
      ST_WRITE: begin
        if (nvm_ack_i) begin
          if (mode_q == MODE_VERIFY) begin
            tries_clr = 1'b1;
            state_d   = ST_VREAD;
          end else begin
            wait_load = 1'b1;
            state_d   = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (wait_expired) state_d = ST_ADV;
      end
      ST_VREAD: begin
        if (nvm_ack_i) begin
          if (nvm_rdata_i == wbyte_q) begin
            state_d = ST_ADV;
          end else if (last_try) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            tries_inc = 1'b1;
          end
        end
      end
      ST_ADV: begin
        if (last_byte) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          idx_d   = idx_q + 1'b1;
          state_d = ST_RADDR;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      job_q   <= JOB_CFG;
      mode_q  <= MODE_TIMED;
      wbyte_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      job_q   <= job_d;
      mode_q  <= mode_d;
      wbyte_q <= wbyte_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // Address of the last acknowledged write, kept for the read-back check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     wr_addr_q <= '0;
    else if (state_q == ST_WRITE && nvm_ack_i)      wr_addr_q <= dst_addr;
  end

  // Outputs
  assign ram_addr_o  = src_addr;
  assign nvm_req_o   = (state_q == ST_WRITE) | (state_q == ST_VREAD);
  assign nvm_we_o    = (state_q == ST_WRITE);
  assign nvm_addr_o  = dst_addr;
  assign nvm_wdata_o = wbyte_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign error_o     = err_q;

  // Assertions
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_req_o && !nvm_ack_i) |=>
      (nvm_req_o && $stable(nvm_we_o) && $stable(nvm_addr_o) && $stable(nvm_wdata_o)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !error_o));

  a_r6_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (!busy_o && !nvm_req_o));

  a_r4_timed_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TIMED) |-> !(nvm_req_o && !nvm_we_o));

  a_r5_read_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_req_o && !nvm_we_o) |-> (nvm_addr_o == wr_addr_q));

  a_r7_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(job_q) && $stable(mode_q)));

  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> ($stable(job_q) && $stable(mode_q)));

endmodule

// File: tb/nvm_copy_seq_tb.sv
module nvm_copy_seq_tb;

  localparam int W_CYC = 10;
  localparam int TRIES = 4;
  localparam int LAT   = 2;

  logic       clk = 1'b0;
  logic       rst_n_i;
  logic       start_i, job_i, mode_i;
  logic [7:0] ram_addr_o, ram_rdata_i;
  logic       nvm_req_o, nvm_we_o, nvm_ack_i;
  logic [7:0] nvm_addr_o, nvm_wdata_o, nvm_rdata_i;
  logic       busy_o, done_o, error_o;

  always #2.5 clk = ~clk;

  nvm_copy_seq #(.WAIT_CYC(W_CYC), .MAX_TRIES(TRIES)) u_dut (
    .clk(clk), .rst_n_i(rst_n_i), .start_i(start_i), .job_i(job_i), .mode_i(mode_i),
    .ram_addr_o(ram_addr_o), .ram_rdata_i(ram_rdata_i),
    .nvm_req_o(nvm_req_o), .nvm_we_o(nvm_we_o), .nvm_addr_o(nvm_addr_o),
    .nvm_wdata_o(nvm_wdata_o), .nvm_ack_i(nvm_ack_i), .nvm_rdata_i(nvm_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
  );

  int errors = 0;
  int checks = 0;

  logic [7:0] ram [256];
  logic [7:0] nvm [256];
  int cyc = 0, lat_cnt = 0, busy_left = 0, busy_cfg = 0;
  int wr_cnt = 0, rd_cnt = 0, done_cnt = 0, stray = 0;
  int last_wr_cyc = 0, min_gap = 1000000;
  bit gap_pending = 0;
  int win_lo = 0, win_hi = 0;

  // Fields: [21] job, [20] mode, [19:16] busy reads, [15:10] writes,
  //         [9:2] reads, [1] error, [0] done count
  localparam logic [21:0] VEC [6] = '{
    {1'b0, 1'b0, 4'd0, 6'd20, 8'd0,  1'b0, 1'b1},
    {1'b1, 1'b0, 4'd0, 6'd7,  8'd0,  1'b0, 1'b1},
    {1'b0, 1'b1, 4'd0, 6'd20, 8'd20, 1'b0, 1'b1},
    {1'b1, 1'b1, 4'd2, 6'd7,  8'd21, 1'b0, 1'b1},
    {1'b0, 1'b1, 4'd3, 6'd20, 8'd80, 1'b0, 1'b1},
    {1'b1, 1'b1, 4'd4, 6'd1,  8'd4,  1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // RAM and nonvolatile memory models, all driven on the falling edge
  initial begin
    nvm_ack_i = 1'b0;
    nvm_rdata_i = '0;
    ram_rdata_i = '0;
    forever begin
      @(negedge clk);
      cyc++;
      ram_rdata_i = ram[ram_addr_o];
      if (done_o) done_cnt++;
      if (nvm_ack_i) begin
        nvm_ack_i = 1'b0;
      end else if (nvm_req_o) begin
        if (lat_cnt == 0 && nvm_we_o && gap_pending) begin
          if (cyc - last_wr_cyc < min_gap) min_gap = cyc - last_wr_cyc;
          gap_pending = 0;
        end
        if (lat_cnt == LAT) begin
          lat_cnt = 0;
          if (nvm_we_o) begin
            nvm[nvm_addr_o] = nvm_wdata_o;
            wr_cnt++;
            busy_left = busy_cfg;
            if (int'(nvm_addr_o) < win_lo || int'(nvm_addr_o) > win_hi) stray++;
            last_wr_cyc = cyc;
            gap_pending = 1;
          end else begin
            rd_cnt++;
            if (busy_left > 0) begin
              nvm_rdata_i = ~nvm[nvm_addr_o];
              busy_left--;
            end else begin
              nvm_rdata_i = nvm[nvm_addr_o];
            end
          end
          nvm_ack_i = 1'b1;
        end else begin
          lat_cnt++;
        end
      end else begin
        lat_cnt = 0;
      end
    end
  end

  task automatic launch(input bit job, input bit mode, input int br);
    @(negedge clk);
    for (int a = 0; a < 256; a++) nvm[a] = 8'hEE;
    wr_cnt = 0; rd_cnt = 0; done_cnt = 0; stray = 0;
    min_gap = 1000000; gap_pending = 0;
    busy_cfg = br;
    win_lo = job ? 'h48 : 'h10;
    win_hi = job ? 'h4E : 'h23;
    job_i = job; mode_i = mode; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic finish_wait;
    for (int t = 0; t < 20000; t++) begin
      if (done_cnt > 0 || error_o) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic bit image_ok(input bit job);
    int src = job ? 'h20 : 'h00;
    int dst = job ? 'h48 : 'h10;
    int n   = job ? 7 : 20;
    for (int b = 0; b < n; b++)
      if (nvm[dst + b] !== ram[src + b]) return 0;
    return 1;
  endfunction

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) ram[a] = 8'(a * 3 + 1);
    rst_n_i = 1'b0; start_i = 1'b0; job_i = 1'b0; mode_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n_i = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk({busy_o, done_o, error_o, nvm_req_o} == 4'b0, "R10 reset outputs",
        {busy_o, done_o, error_o, nvm_req_o}, 0);

    // Vector table
    for (int v = 0; v < 6; v++) begin
      logic [21:0] e;
      e = VEC[v];
      launch(e[21], e[20], int'(e[19:16]));
      chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
      finish_wait();
      chk(wr_cnt == int'(e[15:10]), "R3 write count", wr_cnt, int'(e[15:10]));
      chk(rd_cnt == int'(e[9:2]), e[20] ? "R5 read-back count" : "R4 no reads",
          rd_cnt, int'(e[9:2]));
      chk(error_o == e[1], "R6 error flag", error_o, e[1]);
      chk(done_cnt == int'(e[0]), "R9 done pulse count", done_cnt, int'(e[0]));
      chk(busy_o == 1'b0, "R9 idle busy low", busy_o, 0);
      chk(stray == 0, e[21] ? "R2 window" : "R1 window", stray, 0);
      if (!e[1])
        chk(image_ok(e[21]), e[21] ? "R2 image" : "R1 image", 0, 1);
      if (!e[20])
        chk(min_gap >= W_CYC, "R4 gap", min_gap, W_CYC);
    end

    // R6: error cleared by the next accepted start
    launch(1'b1, 1'b0, 0);
    chk(error_o == 1'b0, "R6 error clear", error_o, 0);
    finish_wait();
    chk(done_cnt == 1 && image_ok(1'b1), "R6 rerun after error", done_cnt, 1);

    // R7: select changes mid-job are ignored
    launch(1'b0, 1'b0, 0);
    repeat (20) @(negedge clk);
    job_i = 1'b1; mode_i = 1'b1;
    finish_wait();
    chk(wr_cnt == 20 && rd_cnt == 0, "R7 sampled selects", wr_cnt * 1000 + rd_cnt, 20000);
    chk(image_ok(1'b0), "R7 image", 0, 1);

    // R8: start while busy is ignored
    launch(1'b1, 1'b1, 1);
    repeat (15) @(negedge clk);
    job_i = 1'b0; mode_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    finish_wait();
    chk(wr_cnt == 7 && rd_cnt == 14 && done_cnt == 1, "R8 busy start",
        wr_cnt * 1000 + rd_cnt, 7014);
    repeat (30) @(negedge clk);
    chk(busy_o == 1'b0 && wr_cnt == 7, "R8 no restart", wr_cnt, 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule